// File: doc/BRIEF.md
# Fractional Stream Rate Pacer

This block sits in series with a valid/ready byte stream and holds its long-term throughput to a fraction N/D of the clock rate. It does this by refusing upstream beats on chosen cycles. A credit accumulator drives the choice. Each accepted beat adds D−N to the accumulator. Each cycle without an accepted beat takes N away, but only while the accumulator is positive. A new beat is admitted only while the accumulator is zero or negative. Payload, byte enables, end-of-frame and the error flag go through one output register without any change.

Two pacing modes are selected by a run-time input. In word mode a stall may fall between any two beats. In frame mode, once the first beat of a frame has been accepted, the rest of the frame is admitted without pacing stalls. The debt from the whole frame is then paid off as idle cycles after the end-of-frame beat. The rate pair and the mode may change at any time without a reset, and the next admission decision uses the new values. Downstream backpressure always takes precedence over pacing.

Top module: `axis_rate_pacer`

## Requirements
- R1: Every accepted beat appears on the output exactly once and in order, with data, keep, last and user unchanged. The output becomes valid on the clock edge after the input handshake.
- R2: In word mode, the output is never backpressured and the input is always valid. Take B beats accepted after reset, and let the (B+1)-th accept come T cycles after the first. Then B·D − T·N lies within [1−N, 0].
- R3: In word mode, starting from reset, the number of stall cycles after the first beat is ceil((D−N)/N).
- R4: In frame mode with no output backpressure, s_ready stays high on every cycle that follows an accepted beat whose last is low. A frame is never split by pacing.
- R5: In frame mode, starting from reset with a continuous source, the stall after a first frame of L beats lasts ceil(L·(D−N)/N) cycles. The bound of R2 also holds when measured over whole frames.
- R6: With N equal to D, no stall cycle is inserted: B beats take exactly B cycles.
- R7: While m_valid is high and m_ready is low, s_ready is low and the output payload holds. Under any backpressure pattern, B·D ≤ T·N holds, with B and T measured as in R2.
- R8: A change of rate_num and rate_den without a reset takes effect on the next admission decision.
- R9: In the first cycle after reset, m_valid is low and s_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_num | input | RATE_W | Rate numerator N, with 1 ≤ N ≤ D |
| rate_den | input | RATE_W | Rate denominator D |
| frame_mode | input | 1 | 1 = stalls only between frames, 0 = stalls at any beat |
| s_data | input | DATA_W | Upstream payload |
| s_keep | input | KEEP_W | Upstream byte enables |
| s_valid | input | 1 | Upstream beat valid |
| s_ready | output | 1 | Upstream beat accepted when high with s_valid |
| s_last | input | 1 | Upstream end of frame |
| s_user | input | 1 | Upstream error flag |
| m_data | output | DATA_W | Downstream payload |
| m_keep | output | KEEP_W | Downstream byte enables (all ones if KEEP_EN is 0) |
| m_valid | output | 1 | Downstream beat valid |
| m_ready | input | 1 | Downstream ready |
| m_last | output | 1 | Downstream end of frame |
| m_user | output | 1 | Downstream error flag |

## Verification
Every rate N/D with D up to 5 is swept in both modes, using single-beat and three-beat frames from a source that never idles. This separates exact stall lengths in word mode from deferred, summed stalls in frame mode, and it exposes any leak of stalls into a frame. The N equal to D points check that full rate inserts nothing. Runs with a periodic downstream stall check that ordering and payload survive, and that backpressure cycles never let the pacer exceed its rate. A rate change made mid-run without a reset checks that the new ratio drives the very next gap.

// File: rtl/axis_rate_pacer.sv
module axis_rate_pacer #(
  parameter int DATA_W    = 16,
  parameter int KEEP_EN   = 1,
  parameter int KEEP_W    = (DATA_W + 7) / 8,
  parameter int RATE_W    = 4,
  parameter int MAX_FRAME = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_num,
  input  logic [RATE_W-1:0] rate_den,
  input  logic              frame_mode,
  input  logic [DATA_W-1:0] s_data,
  input  logic [KEEP_W-1:0] s_keep,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_last,
  input  logic              s_user,
  output logic [DATA_W-1:0] m_data,
  output logic [KEEP_W-1:0] m_keep,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_last,
  output logic              m_user
);
  localparam int ACC_W = RATE_W + $clog2(MAX_FRAME + 1) + 2;
  localparam logic signed [ACC_W:0] ACC_TOP = $signed({2'b00, {(ACC_W-1){1'b1}}});

  logic signed [ACC_W-1:0] acc;
  logic                    in_frame;

  wire signed [ACC_W:0]   num_w = $signed({{(ACC_W+1-RATE_W){1'b0}}, rate_num});
  wire signed [ACC_W:0]   den_w = $signed({{(ACC_W+1-RATE_W){1'b0}}, rate_den});
  wire signed [ACC_W:0]   acc_w = {acc[ACC_W-1], acc};
  wire signed [ACC_W:0]   grown = acc_w + den_w - num_w;
  wire signed [ACC_W:0]   paid  = acc_w - num_w;

  wire pace_ok = (acc <= 0) || (frame_mode && in_frame);
  wire out_free = !m_valid || m_ready;
  assign s_ready = pace_ok && out_free;
  wire fire = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      in_frame <= 1'b0;
    end else begin
      if (fire) begin
        in_frame <= !s_last;
        acc      <= (grown > ACC_TOP) ? ACC_TOP[ACC_W-1:0] : grown[ACC_W-1:0];
      end else if (acc > 0) begin
        acc <= paid[ACC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_last  <= 1'b0;
      m_user  <= 1'b0;
    end else if (fire) begin
      m_valid <= 1'b1;
      m_data  <= s_data;
      m_last  <= s_last;
      m_user  <= s_user;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  generate
    if (KEEP_EN != 0) begin : g_keep
      logic [KEEP_W-1:0] keep_q;
      always_ff @(posedge clk) begin
        if (rst)       keep_q <= '0;
        else if (fire) keep_q <= s_keep;
      end
      assign m_keep = keep_q;
    end else begin : g_nokeep
      logic unused_keep;
      assign unused_keep = ^s_keep;
      assign m_keep = '1;
    end
  endgenerate
endmodule

// File: rtl/axis_rate_pacer_chk.sv
module axis_rate_pacer_chk #(
  parameter int DATA_W = 16,
  parameter int KEEP_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_mode,
  input logic [DATA_W-1:0] s_data,
  input logic              s_valid,
  input logic              s_ready,
  input logic              s_last,
  input logic              s_user,
  input logic [DATA_W-1:0] m_data,
  input logic              m_valid,
  input logic              m_ready,
  input logic              m_last,
  input logic              m_user
);
  p_reset_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !m_valid);

  p_fire_to_out_r1: assert property (@(posedge clk) disable iff (rst)
    $past(s_valid && s_ready) |-> (m_valid && m_data == $past(s_data)
      && m_last == $past(s_last) && m_user == $past(s_user)));

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  p_block_on_bp_r7: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |-> !s_ready);

  p_frame_no_gap_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(frame_mode && s_valid && s_ready && !s_last) && frame_mode && m_ready) |-> s_ready);
endmodule

bind axis_rate_pacer axis_rate_pacer_chk #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_chk (
  .clk(clk), .rst(rst), .frame_mode(frame_mode),
  .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready), .s_last(s_last), .s_user(s_user),
  .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready), .m_last(m_last), .m_user(m_user)
);

// File: tb/axis_rate_pacer_bench.sv
module axis_rate_pacer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int KW = 2;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [RW-1:0] rate_num = 4'd1;
  logic [RW-1:0] rate_den = 4'd1;
  logic          frame_mode = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic [KW-1:0] s_keep = '0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic          s_last = 1'b0;
  logic          s_user = 1'b0;
  logic [DW-1:0] m_data;
  logic [KW-1:0] m_keep;
  logic          m_valid;
  logic          m_ready = 1'b1;
  logic          m_last;
  logic          m_user;

  int n_tests = 0;
  int n_fail  = 0;
  int wd      = 0;
  int acc_cyc [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  axis_rate_pacer #(.DATA_W(DW), .KEEP_EN(1), .KEEP_W(KW), .RATE_W(RW), .MAX_FRAME(16))
  u_axis_rate_pacer (
    .clk(clk), .rst(rst), .rate_num(rate_num), .rate_den(rate_den), .frame_mode(frame_mode),
    .s_data(s_data), .s_keep(s_keep), .s_valid(s_valid), .s_ready(s_ready),
    .s_last(s_last), .s_user(s_user),
    .m_data(m_data), .m_keep(m_keep), .m_valid(m_valid), .m_ready(m_ready),
    .m_last(m_last), .m_user(m_user)
  );

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      n_tests = n_tests + 1;
      n_fail  = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", wd);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests = n_tests + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] b_data(int k); return DW'(k * 37 + 5); endfunction
  function automatic logic [KW-1:0] b_keep(int k); return KW'(k % 3 + 1); endfunction
  function automatic logic b_user(int k); return (k % 4) == 3; endfunction
  function automatic logic b_last(int k, int len); return ((k + 1) % len) == 0; endfunction

  task automatic do_reset();
    s_valid = 1'b0;
    m_ready = 1'b1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input bit fm, input int n, input int d, input int len,
                     input int nb, input bit bp, input bit rs);
    int sent = 0;
    int rx = 0;
    int cyc = 0;
    int bad = 0;
    int t, bd, tn;
    frame_mode = fm;
    rate_num = RW'(n);
    rate_den = RW'(d);
    if (rs) do_reset();
    while ((sent <= nb || rx < sent) && cyc < 3000) begin
      @(negedge clk);
      m_ready = bp ? ((cyc % 3) != 2) : 1'b1;
      s_valid = (sent <= nb);
      s_data  = b_data(sent);
      s_keep  = b_keep(sent);
      s_user  = b_user(sent);
      s_last  = b_last(sent, len);
      #1;
      if (m_valid && m_ready) begin
        if (m_data != b_data(rx) || m_keep != b_keep(rx) || m_user != b_user(rx)
            || m_last != b_last(rx, len)) bad = bad + 1;
        rx = rx + 1;
      end
      if (s_valid && s_ready) begin
        if (sent < 16) acc_cyc[sent] = cyc;
        sent = sent + 1;
      end
      cyc = cyc + 1;
    end
    s_valid = 1'b0;
    m_ready = 1'b1;
    check(bad == 0 && rx == nb + 1, "R1 payload order", bad, 0);
    t  = acc_cyc[nb] - acc_cyc[0];
    bd = nb * d;
    tn = t * n;
    if (bp) begin
      check(bd <= tn, "R7 rate under backpressure", bd, tn);
    end else begin
      check(bd - tn >= 1 - n && bd - tn <= 0, fm ? "R5 frame rate bound" : "R2 word rate bound",
            bd - tn, 0);
      if (n == d) check(t == nb, "R6 full rate no stall", t, nb);
      if (!fm) begin
        check(acc_cyc[1] - acc_cyc[0] - 1 == (d - n + n - 1) / n, "R3 first word gap",
              acc_cyc[1] - acc_cyc[0] - 1, (d - n + n - 1) / n);
      end else begin
        for (int i = 1; i < len; i++)
          check(acc_cyc[i] - acc_cyc[i-1] == 1, "R4 no gap in frame",
                acc_cyc[i] - acc_cyc[i-1], 1);
        check(acc_cyc[len] - acc_cyc[len-1] - 1 == (len * (d - n) + n - 1) / n,
              "R5 stall after frame", acc_cyc[len] - acc_cyc[len-1] - 1,
              (len * (d - n) + n - 1) / n);
      end
    end
  endtask

  initial begin
    do_reset();
    #1;
    check(m_valid == 1'b0, "R9 reset m_valid", m_valid, 0);
    check(s_ready == 1'b1, "R9 reset s_ready", s_ready, 1);

    for (int fm = 0; fm < 2; fm++)
      for (int d = 1; d <= 5; d++)
        for (int n = 1; n <= d; n++) begin
          run(fm[0], n, d, 1, 6, 1'b0, 1'b1);
          run(fm[0], n, d, 3, 6, 1'b0, 1'b1);
        end

    run(1'b0, 2, 3, 4, 8, 1'b1, 1'b1);
    run(1'b0, 1, 4, 4, 8, 1'b1, 1'b1);
    run(1'b1, 3, 5, 2, 8, 1'b1, 1'b1);
    run(1'b1, 4, 4, 3, 9, 1'b1, 1'b1);

    run(1'b0, 4, 4, 4, 4, 1'b0, 1'b1);
    run(1'b0, 1, 4, 4, 4, 1'b0, 1'b0);
    check(acc_cyc[1] - acc_cyc[0] - 1 == 3, "R8 rate change without reset",
          acc_cyc[1] - acc_cyc[0] - 1, 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule